// File: doc/BRIEF.md
# Serial-to-Parallel Scan Compression Port

This block lets a handful of tester scan pins feed a wide compression engine. In serial mode, each serial scan-in pin fills its own slice of a shift register. When every slice is full, an update copies the whole word into a holding register. That register drives the decompressor inputs unchanged until the next word is complete. At the same clock edge, a serializer takes in the compressor outputs. It then shifts them out, lowest bit first, on the serial scan-out pins while the next input word is being collected. One internal scan shift therefore costs SEG = N_BITS / N_SER serial clocks.

A controller produces three outputs: the update pulse, a one-cycle internal scan strobe, and a one-cycle mask-register strobe. A mode input decides which of the two strobes follows a given update, so mask and clock-control data use the same input path as scan data. A parallel-access input bypasses the shift logic so that direct scan pins feed the decompressor. When the interface enable is low, all of the block's registers form a single plain shift chain, so that ordinary full-scan test can reach them.

Top module: `serscan_port`

## Requirements
- R1: In serial mode (`iface_en`=1, `par_sel`=0), `upd_pulse` is high for exactly one cycle out of every SEG cycles. The first pulse comes in the SEG-th cycle after serial mode starts from reset.
- R2: The bit driven on `ser_in[p]` in the j-th cycle (j = 0..SEG-1) of a serial word appears on `dec_out[p*SEG+j]` after the update at the end of that word.
- R3: In serial mode, `dec_out` stays constant except on the clock edge that ends an update cycle.
- R4: In parallel mode (`iface_en`=1, `par_sel`=1), `dec_out` equals `par_in` in the same cycle and `upd_pulse` stays low.
- R5: `scan_clk_en` and `mask_clk_en` are never high together. In serial mode, the value of `mask_mode` in the update cycle picks which strobe fires. In parallel mode, the strobes follow `mask_mode` directly, with `scan_clk_en` = !`mask_mode`.
- R6: In serial mode, exactly one strobe is high in the cycle right after each update, and none is high at any other time.
- R7: The serializer captures `cmp_in` on the update edge. In the j-th cycle after that edge, `ser_out[p]` equals the captured bit `cmp_in[p*SEG+j]`.
- R8: With `iface_en`=0, no strobe and no update fire. The registers form one 3*N_BITS-stage chain from `ser_in[0]` to `ser_out[0]`. A bit entered in cycle t leaves at `ser_out[0]` in cycle t+3*N_BITS, and `dec_out[i]` shows the bit entered 2*N_BITS-i cycles earlier.
- R9: A synchronous reset clears the bit counter, shift register, hold register and serializer. Afterwards `dec_out` and `ser_out` read zero in serial mode and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial shift clock |
| rst | input | 1 | Synchronous active-high reset |
| iface_en | input | 1 | Interface enable; low selects the full-scan chain |
| par_sel | input | 1 | High selects direct parallel scan pins |
| mask_mode | input | 1 | High marks the current word as mask/clock-control data |
| ser_in | input | N_SER | Serial scan-in pins |
| par_in | input | N_BITS | Direct parallel scan-in pins |
| cmp_in | input | N_BITS | Compressor outputs to serialize |
| dec_out | output | N_BITS | Word presented to the decompressor |
| ser_out | output | N_SER | Serial scan-out pins |
| upd_pulse | output | 1 | Update / capture pulse |
| scan_clk_en | output | 1 | Internal scan shift strobe |
| mask_clk_en | output | 1 | Mask register load strobe |

## Verification
The bench uses N_BITS=8 split over N_SER=2 pins, so each slice is 4 bits and a full word takes four cycles. With two slices, a swap of pin-to-slice mapping or of bit order within a slice shows up, and four-cycle words keep runs short. The 24-stage full-scan chain is short enough to flush completely with random bits. A strobe-type scoreboard pairs every update with the word and the strobe it must produce, so that scan and mask words can be interleaved in one run.

// File: rtl/serscan_pkg.sv
package serscan_pkg;

    typedef enum logic [1:0] {
        MD_FSCAN = 2'd0,
        MD_PAR   = 2'd1,
        MD_SER   = 2'd2
    } serscan_mode_e;

    typedef struct packed {
        logic scan;
        logic mask;
    } strobe_t;

    function automatic serscan_mode_e decode_mode(input logic en, input logic par);
        if (!en)
            return MD_FSCAN;
        else if (par)
            return MD_PAR;
        else
            return MD_SER;
    endfunction

endpackage

// File: rtl/serscan_ctrl.sv
module serscan_ctrl
    import serscan_pkg::*;
#(
    parameter int SEG = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  serscan_mode_e mode,
    input  logic          mask_mode,
    output logic          upd,
    output strobe_t       strobe
);
    localparam int CW = (SEG > 1) ? $clog2(SEG) : 1;
    localparam logic [CW-1:0] LAST = CW'(SEG - 1);

    logic [CW-1:0] cnt;
    strobe_t       strb_q;

    assign upd = (mode == MD_SER) && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            strb_q <= '0;
        end else if (mode != MD_SER) begin
            cnt    <= '0;
            strb_q <= '0;
        end else begin
            cnt         <= upd ? '0 : cnt + CW'(1);
            strb_q.scan <= upd & ~mask_mode;
            strb_q.mask <= upd & mask_mode;
        end
    end

    always_comb begin
        case (mode)
            MD_PAR:  begin strobe.scan = ~mask_mode; strobe.mask = mask_mode; end
            MD_SER:  strobe = strb_q;
            default: strobe = '0;
        endcase
    end

endmodule

// File: rtl/serscan_deser.sv
module serscan_deser
    import serscan_pkg::*;
#(
    parameter int N_BITS = 8,
    parameter int N_SER  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  serscan_mode_e     mode,
    input  logic              upd,
    input  logic [N_SER-1:0]  ser_in,
    output logic [N_BITS-1:0] hold
);
    localparam int SEG = N_BITS / N_SER;

    logic [N_BITS-1:0] sh;
    logic [N_BITS-1:0] sh_nxt;

    // each slice shifts toward its low end; the pin enters at the top
    for (genvar p = 0; p < N_SER; p++) begin : g_slice
        assign sh_nxt[p*SEG +: SEG] = {ser_in[p], sh[p*SEG+1 +: SEG-1]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '0;
            hold <= '0;
        end else begin
            case (mode)
                MD_SER: begin
                    sh <= sh_nxt;
                    if (upd)
                        hold <= sh_nxt;
                end
                MD_FSCAN: {sh, hold} <= {ser_in[0], sh, hold[N_BITS-1:1]};
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/serscan_ser.sv
module serscan_ser
    import serscan_pkg::*;
#(
    parameter int N_BITS = 8,
    parameter int N_SER  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  serscan_mode_e     mode,
    input  logic              upd,
    input  logic              chain_in,
    input  logic [N_BITS-1:0] cmp_in,
    output logic [N_SER-1:0]  ser_out
);
    localparam int SEG = N_BITS / N_SER;

    logic [N_BITS-1:0] sr;
    logic [N_BITS-1:0] sr_nxt;

    for (genvar p = 0; p < N_SER; p++) begin : g_slice
        assign sr_nxt[p*SEG +: SEG] = {1'b0, sr[p*SEG+1 +: SEG-1]};
        assign ser_out[p]           = sr[p*SEG];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= '0;
        end else begin
            case (mode)
                MD_SER:   sr <= upd ? cmp_in : sr_nxt;
                MD_FSCAN: sr <= {chain_in, sr[N_BITS-1:1]};
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/serscan_port.sv
module serscan_port
    import serscan_pkg::*;
#(
    parameter int N_BITS = 8,
    parameter int N_SER  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              iface_en,
    input  logic              par_sel,
    input  logic              mask_mode,
    input  logic [N_SER-1:0]  ser_in,
    input  logic [N_BITS-1:0] par_in,
    input  logic [N_BITS-1:0] cmp_in,
    output logic [N_BITS-1:0] dec_out,
    output logic [N_SER-1:0]  ser_out,
    output logic              upd_pulse,
    output logic              scan_clk_en,
    output logic              mask_clk_en
);
    localparam int SEG = N_BITS / N_SER;

    serscan_mode_e     mode;
    strobe_t           strobe;
    logic [N_BITS-1:0] hold;

    assign mode = decode_mode(iface_en, par_sel);

    serscan_ctrl #(.SEG(SEG)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .mask_mode (mask_mode),
        .upd       (upd_pulse),
        .strobe    (strobe)
    );

    serscan_deser #(.N_BITS(N_BITS), .N_SER(N_SER)) u_deser (
        .clk    (clk),
        .rst    (rst),
        .mode   (mode),
        .upd    (upd_pulse),
        .ser_in (ser_in),
        .hold   (hold)
    );

    serscan_ser #(.N_BITS(N_BITS), .N_SER(N_SER)) u_ser (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .upd      (upd_pulse),
        .chain_in (hold[0]),
        .cmp_in   (cmp_in),
        .ser_out  (ser_out)
    );

    assign dec_out     = (mode == MD_PAR) ? par_in : hold;
    assign scan_clk_en = strobe.scan;
    assign mask_clk_en = strobe.mask;

endmodule

// File: rtl/serscan_chk.sv
module serscan_chk #(
    parameter int N_BITS = 8,
    parameter int N_SER  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              iface_en,
    input logic              par_sel,
    input logic [N_BITS-1:0] cmp_in,
    input logic [N_BITS-1:0] dec_out,
    input logic [N_SER-1:0]  ser_out,
    input logic              upd_pulse,
    input logic              scan_clk_en,
    input logic              mask_clk_en
);
    localparam int SEG = N_BITS / N_SER;
    localparam int CW  = (SEG > 1) ? $clog2(SEG) : 1;

    logic          ser_m;
    logic          past_ok;
    logic [CW-1:0] gap;
    logic [N_SER-1:0] cmp_lsb;

    assign ser_m = iface_en && !par_sel;

    for (genvar p = 0; p < N_SER; p++) begin : g_lsb
        assign cmp_lsb[p] = cmp_in[p*SEG];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            past_ok <= 1'b0;
            gap     <= '0;
        end else begin
            past_ok <= 1'b1;
            if (!ser_m || upd_pulse)
                gap <= '0;
            else
                gap <= gap + CW'(1);
        end
    end

    AST_UPD_DUE: assert property (@(posedge clk) disable iff (rst)
        (ser_m && gap == CW'(SEG - 1)) |-> upd_pulse);                         // R1
    AST_UPD_ONLY_DUE: assert property (@(posedge clk) disable iff (rst)
        upd_pulse |-> (ser_m && gap == CW'(SEG - 1)));                         // R1
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (past_ok && ser_m && $past(ser_m) && !$past(upd_pulse)) |-> $stable(dec_out)); // R3
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(scan_clk_en && mask_clk_en));                                        // R5
    AST_STROBE_AFTER_UPD: assert property (@(posedge clk) disable iff (rst)
        (past_ok && ser_m && $past(ser_m) && $past(upd_pulse)) |-> (scan_clk_en || mask_clk_en)); // R6
    AST_NO_STRAY_STROBE: assert property (@(posedge clk) disable iff (rst)
        (past_ok && ser_m && $past(ser_m) && !$past(upd_pulse)) |-> !(scan_clk_en || mask_clk_en)); // R6
    AST_SEROUT_FIRST: assert property (@(posedge clk) disable iff (rst)
        (past_ok && ser_m && $past(ser_m) && $past(upd_pulse)) |-> (ser_out == $past(cmp_lsb))); // R7
    AST_FSCAN_QUIET: assert property (@(posedge clk) disable iff (rst)
        !iface_en |-> (!scan_clk_en && !mask_clk_en && !upd_pulse));           // R8

endmodule

bind serscan_port serscan_chk #(.N_BITS(N_BITS), .N_SER(N_SER)) i_chk (
    .clk         (clk),
    .rst         (rst),
    .iface_en    (iface_en),
    .par_sel     (par_sel),
    .cmp_in      (cmp_in),
    .dec_out     (dec_out),
    .ser_out     (ser_out),
    .upd_pulse   (upd_pulse),
    .scan_clk_en (scan_clk_en),
    .mask_clk_en (mask_clk_en)
);

// File: tb/test_serscan_port.sv
`timescale 1ns/1ps
module test_serscan_port;
    localparam int NB  = 8;
    localparam int NS  = 2;
    localparam int SEG = NB / NS;
    localparam int CH  = 3 * NB;
    localparam int FSL = CH + 24;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          iface_en = 1'b1;
    logic          par_sel = 1'b0;
    logic          mask_mode = 1'b0;
    logic [NS-1:0] ser_in = '0;
    logic [NB-1:0] par_in = '0;
    logic [NB-1:0] cmp_in = '0;
    logic [NB-1:0] dec_out;
    logic [NS-1:0] ser_out;
    logic          upd_pulse, scan_clk_en, mask_clk_en;

    int tests = 0;
    int fails = 0;

    typedef struct {
        logic [NB-1:0] word;
        logic          is_mask;
    } exp_t;
    exp_t sb_q[$];
    bit   mon_on = 0;

    logic [NB-1:0] prev_w = '0;
    logic [NB-1:0] prev_cmp = '0;

    always #2.5 clk = ~clk;

    serscan_port #(.N_BITS(NB), .N_SER(NS)) i_serscan_port (
        .clk(clk), .rst(rst), .iface_en(iface_en), .par_sel(par_sel),
        .mask_mode(mask_mode), .ser_in(ser_in), .par_in(par_in), .cmp_in(cmp_in),
        .dec_out(dec_out), .ser_out(ser_out), .upd_pulse(upd_pulse),
        .scan_clk_en(scan_clk_en), .mask_clk_en(mask_clk_en)
    );

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
        end
    endtask

    // monitor: every strobe must match the next scoreboard entry
    always @(negedge clk) begin
        if (mon_on && !rst && (scan_clk_en || mask_clk_en)) begin
            if (sb_q.size() == 0) begin
                chk(0, "R6 unexpected strobe", {30'd0, scan_clk_en, mask_clk_en}, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(dec_out == e.word, "R2 word at strobe", dec_out, e.word);
                chk(mask_clk_en == e.is_mask && scan_clk_en == !e.is_mask,
                    "R5 strobe kind", {30'd0, scan_clk_en, mask_clk_en}, {30'd0, !e.is_mask, e.is_mask});
            end
        end
    end

    // entered and left at a falling edge
    task automatic do_reset();
        rst = 1'b1; iface_en = 1'b1; par_sel = 1'b0; mask_mode = 1'b0;
        ser_in = '0; cmp_in = '0; par_in = '0; mon_on = 0;
        sb_q.delete();
        repeat (2) @(negedge clk);
        chk(dec_out == '0, "R9 dec_out after reset", dec_out, 0);
        chk(ser_out == '0, "R9 ser_out after reset", ser_out, 0);
        chk(!scan_clk_en && !mask_clk_en, "R9 strobes after reset", {30'd0, scan_clk_en, mask_clk_en}, 0);
        prev_w = '0; prev_cmp = '0;
        rst = 1'b0;
    endtask

    // driver: one serial word, called at a falling edge
    task automatic ser_word(input logic [NB-1:0] w, input logic [NB-1:0] cmp, input bit mk);
        for (int j = 0; j < SEG; j++) begin
            for (int p = 0; p < NS; p++)
                chk(ser_out[p] == prev_cmp[p*SEG+j], "R7 serial out bit", ser_out[p], prev_cmp[p*SEG+j]);
            chk(dec_out == prev_w, "R3 held word", dec_out, prev_w);
            chk(upd_pulse == (j == SEG-1), "R1 update timing", upd_pulse, (j == SEG-1));
            for (int p = 0; p < NS; p++)
                ser_in[p] = w[p*SEG+j];
            cmp_in = cmp;
            mask_mode = mk;
            if (j == SEG-1)
                sb_q.push_back('{word: w, is_mask: mk});
            @(negedge clk);
        end
        prev_w = w;
        prev_cmp = cmp;
    endtask

    initial begin
        logic hist [0:FSL];
        logic q_bits[$];

        // serial phase: scan and mask words interleaved
        @(negedge clk);
        do_reset();
        mon_on = 1;
        ser_word(8'hA5, 8'h3C, 1'b0);
        ser_word(8'h5A, 8'hC3, 1'b1);
        ser_word(8'hFF, 8'h00, 1'b0);
        ser_word(8'h01, 8'h80, 1'b0);
        ser_word(8'h80, 8'h01, 1'b1);
        for (int k = 0; k < 6; k++)
            ser_word(NB'($urandom), NB'($urandom), 1'($urandom));
        ser_word(8'h00, 8'h00, 1'b0);
        @(posedge clk);
        mon_on = 0;
        @(negedge clk);
        chk(sb_q.size() == 0, "R6 every update strobed", sb_q.size(), 0);

        // parallel phase
        do_reset();
        par_sel = 1'b1;
        for (int k = 0; k < 6; k++) begin
            par_in = (k == 0) ? 8'h96 : NB'($urandom);
            mask_mode = k[0];
            #1;
            chk(dec_out == par_in, "R4 parallel pass", dec_out, par_in);
            chk(upd_pulse == 1'b0, "R4 no update", upd_pulse, 0);
            chk(scan_clk_en == !mask_mode && mask_clk_en == mask_mode, "R5 parallel strobes",
                {30'd0, scan_clk_en, mask_clk_en}, {30'd0, !mask_mode, mask_mode});
            @(negedge clk);
        end

        // full-scan chain phase
        do_reset();
        iface_en = 1'b0;
        for (int t = 0; t < FSL; t++) begin
            if (t > 0) begin
                chk(!scan_clk_en && !mask_clk_en && !upd_pulse, "R8 quiet",
                    {29'd0, scan_clk_en, mask_clk_en, upd_pulse}, 0);
            end
            if (t >= CH) begin
                logic e;
                e = q_bits.pop_front();
                chk(ser_out[0] == e, "R8 chain out", ser_out[0], e);
            end
            if (t >= 2*NB) begin
                for (int i = 0; i < NB; i++)
                    chk(dec_out[i] == hist[t-2*NB+i], "R8 chain hold", dec_out[i], hist[t-2*NB+i]);
            end
            hist[t] = 1'($urandom);
            ser_in = {1'($urandom), hist[t]};
            q_bits.push_back(hist[t]);
            @(negedge clk);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #500000;
        tests++;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule